// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. Its storage is a plain two-port register array. Logic around the array does the addressing and the status reporting. Each side keeps its own binary pointer, one bit wider than the address, together with a Gray-coded copy. The Gray copy passes through a chain of synchronizing flops into the other clock domain. Full and almost-full are computed on the write clock. Empty and almost-empty are computed on the read clock.

Each flag is computed from the local pointer and the synchronized copy of the far pointer. A flag therefore goes true on the same local clock edge that moves the local pointer. It goes false only after the far pointer's movement has crossed the synchronizer. This keeps every flag conservative: the producer never overruns the buffer, and the consumer never reads a slot that is not yet written.

There are two resets. A global reset clears both pointers, every flag and the read data register. A second input, synchronous to the read clock, returns only the read pointer to zero, so the words already stored can be read again from the first one. The almost-full and almost-empty thresholds are parameters.

Top module: `dual_clock_fifo`

## Requirements
- R1: While and after the global reset `rst`, empty=1, almostEmpty=1, full=0, almostFull=0 and rdData=0.
- R2: Words leave in the order they were accepted. rdData takes the word on the first read-clock edge after an accepted read and holds it until the next accepted read.
- R3: full rises on the write-clock edge that stores the DEPTH-th unread word (DEPTH=16 by default). A write while full=1 changes neither the stored words nor the write pointer, so no such word is ever read out.
- R4: empty rises on the read-clock edge that takes the last stored word. A read while empty=1 leaves the read pointer and rdData unchanged.
- R5: full and empty clear only after the far pointer has passed the synchronizer. Right after the far side moves, the flag is still set, and it is clear once a few cycles of both clocks have passed.
- R6: almostFull is 1 exactly when the write-side fill count is at least AF_LEVEL (default 12). It rises on the edge of the write that reaches that count.
- R7: almostEmpty is 1 exactly when the read-side fill count is at most AE_LEVEL (default 3). It rises on the edge of the read that reaches that count.
- R8: A one-cycle pulse on rdPtrRst, sampled on the read clock, sets only the read pointer to zero, and it takes priority over a read in the same cycle. The words written since the last global reset then read out again from the first one.
- R9: A global reset applied in the middle of operation empties the buffer and restores the R1 flag state.
- R10: full=1 implies almostFull=1, and empty=1 implies almostEmpty=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rst | input | 1 | Global reset, asynchronous, active high |
| rdPtrRst | input | 1 | Read-pointer rewind, synchronous to rdClk, active high |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Registered read word |
| full | output | 1 | No free slot (write domain) |
| almostFull | output | 1 | Fill count at or above AF_LEVEL (write domain) |
| empty | output | 1 | No unread word (read domain) |
| almostEmpty | output | 1 | Fill count at or below AE_LEVEL (read domain) |

## Verification
The assertions assume that rdPtrRst is used only while the write pointer has not yet wrapped past the start of the buffer since the last global reset. Otherwise the rewound fill count could exceed DEPTH, and the bound on the write-side fill count would not hold. They also assume AE_LEVEL is below DEPTH and AF_LEVEL is between 1 and DEPTH, so that the flag implications hold. The stimulus pulses rdPtrRst only in a directed test that writes five words after a fresh global reset. The random traffic is driven strictly by the observed flags, and it never touches the rewind input.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  // Strobes handed from the pointer control to the storage datapath.
  typedef struct packed {
    logic wrGo;   // write accepted on this wrClk edge
    logic rdGo;   // read accepted on this rdClk edge
  } fifoStb_t;

endpackage

// File: rtl/afifo_gray_sync.sv
module afifo_gray_sync #(
  parameter int PTR_W  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] grayIn,
  output logic [PTR_W-1:0] binOut
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][PTR_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= '0;
        else     chain[0] <= grayIn;
      end
    end else begin : g_many
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], grayIn};
      end
    end
  endgenerate

  // Gray to binary: each bit is the XOR of all Gray bits at or above it.
  always_comb begin
    for (int i = 0; i < PTR_W; i++) begin
      binOut[i] = ^(chain[LAST] >> i);
    end
  end

endmodule

// File: rtl/afifo_ctrl.sv
module afifo_ctrl
  import afifo_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int AF_LEVEL = 12,
  parameter int AE_LEVEL = 3,
  parameter int STAGES   = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rst,
  input  logic              rdPtrRst,
  input  logic              wrEn,
  input  logic              rdEn,
  output fifoStb_t          stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              full,
  output logic              almostFull,
  output logic              empty,
  output logic              almostEmpty
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] AF_P    = PTR_W'(AF_LEVEL);
  localparam logic [PTR_W-1:0] AE_P    = PTR_W'(AE_LEVEL);

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wPtrBin, wPtrGray, wPtrNext;
  logic [PTR_W-1:0] rPtrAtW;     // read pointer as seen on wrClk
  logic [PTR_W-1:0] wFill;
  logic             wrGo;

  assign full = (wPtrBin[ADDR_W] != rPtrAtW[ADDR_W]) &&
                (wPtrBin[ADDR_W-1:0] == rPtrAtW[ADDR_W-1:0]);
  assign wFill      = wPtrBin - rPtrAtW;
  assign almostFull = (wFill >= AF_P);
  assign wrGo       = wrEn && !full;
  assign wPtrNext   = wPtrBin + PTR_W'(1);

  always_ff @(posedge wrClk or posedge rst) begin
    if (rst) begin
      wPtrBin  <= '0;
      wPtrGray <= '0;
    end else if (wrGo) begin
      wPtrBin  <= wPtrNext;
      wPtrGray <= wPtrNext ^ (wPtrNext >> 1);
    end
  end

  // ---------------- read domain ----------------
  logic [PTR_W-1:0] rPtrBin, rPtrGray, rPtrNext;
  logic [PTR_W-1:0] wPtrAtR;     // write pointer as seen on rdClk
  logic [PTR_W-1:0] rFill;
  logic             rdGo;

  assign empty       = (rPtrBin == wPtrAtR);
  assign rFill       = wPtrAtR - rPtrBin;
  assign almostEmpty = (rFill <= AE_P);
  assign rdGo        = rdEn && !empty && !rdPtrRst;
  assign rPtrNext    = rPtrBin + PTR_W'(1);

  always_ff @(posedge rdClk or posedge rst) begin
    if (rst) begin
      rPtrBin  <= '0;
      rPtrGray <= '0;
    end else if (rdPtrRst) begin
      rPtrBin  <= '0;
      rPtrGray <= '0;
    end else if (rdGo) begin
      rPtrBin  <= rPtrNext;
      rPtrGray <= rPtrNext ^ (rPtrNext >> 1);
    end
  end

  // ---------------- crossings ----------------
  afifo_gray_sync #(.PTR_W(PTR_W), .STAGES(STAGES)) u_rToW (
    .clk(wrClk), .rst(rst), .grayIn(rPtrGray), .binOut(rPtrAtW)
  );

  afifo_gray_sync #(.PTR_W(PTR_W), .STAGES(STAGES)) u_wToR (
    .clk(rdClk), .rst(rst), .grayIn(wPtrGray), .binOut(wPtrAtR)
  );

  assign stb.wrGo = wrGo;
  assign stb.rdGo = rdGo;
  assign wrAddr   = wPtrBin[ADDR_W-1:0];
  assign rdAddr   = rPtrBin[ADDR_W-1:0];

  // ---------------- assertions ----------------
  a_r3_no_overflow: assert property (@(posedge wrClk) disable iff (rst)
    wFill <= DEPTH_P)
    else $error("write-side fill count exceeds depth");

  a_r3_full_blocks_write: assert property (@(posedge wrClk) disable iff (rst)
    (full && wrEn) |=> $stable(wPtrBin))
    else $error("write pointer moved while full");

  a_r4_empty_blocks_read: assert property (@(posedge rdClk) disable iff (rst)
    (empty && rdEn && !rdPtrRst) |=> $stable(rPtrBin))
    else $error("read pointer moved while empty");

  a_r8_rewind_zero: assert property (@(posedge rdClk) disable iff (rst)
    rdPtrRst |=> (rPtrBin == '0))
    else $error("read pointer not cleared by rewind");

endmodule

// File: rtl/afifo_mem.sv
module afifo_mem
  import afifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rst,
  input  fifoStb_t          stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrGo) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or posedge rst) begin
    if (rst)            rdData <= '0;
    else if (stb.rdGo)  rdData <= store[rdAddr];
  end

endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import afifo_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int AF_LEVEL = 12,
  parameter int AE_LEVEL = 3,
  parameter int STAGES   = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rst,
  input  logic              rdPtrRst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              full,
  output logic              almostFull,
  output logic              empty,
  output logic              almostEmpty
);

  fifoStb_t          stb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  afifo_ctrl #(
    .ADDR_W(ADDR_W), .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL), .STAGES(STAGES)
  ) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rst(rst), .rdPtrRst(rdPtrRst),
    .wrEn(wrEn), .rdEn(rdEn), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .full(full), .almostFull(almostFull), .empty(empty), .almostEmpty(almostEmpty)
  );

  afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wrClk(wrClk), .rdClk(rdClk), .rst(rst), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );

  a_r4_hold_q: assert property (@(posedge rdClk) disable iff (rst)
    (!rdEn || empty || rdPtrRst) |=> $stable(rdData))
    else $error("read data changed without an accepted read");

  a_r10_full_af: assert property (@(posedge wrClk) disable iff (rst)
    full |-> almostFull)
    else $error("full without almost full");

  a_r10_empty_ae: assert property (@(posedge rdClk) disable iff (rst)
    empty |-> almostEmpty)
    else $error("empty without almost empty");

endmodule

// File: tb/sim_dual_clock_fifo.sv
module sim_dual_clock_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int AF_LEVEL = 12;
  localparam int AE_LEVEL = 3;

  logic wrClk = 0, rdClk = 0, rst = 1, rdPtrRst = 0, wrEn = 0, rdEn = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic full, almostFull, empty, almostEmpty;

  int nChecks = 0;
  int nFails  = 0;
  logic [DATA_W-1:0] model[$];
  logic [DATA_W-1:0] got;

  always #(CLK_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2)  rdClk = ~rdClk;

  dual_clock_fifo #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL), .STAGES(2)
  ) u0 (
    .wrClk(wrClk), .rdClk(rdClk), .rst(rst), .rdPtrRst(rdPtrRst),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .full(full), .almostFull(almostFull), .empty(empty), .almostEmpty(almostEmpty)
  );

  function automatic logic expAf(int fill); return fill >= AF_LEVEL; endfunction
  function automatic logic expAe(int fill); return fill <= AE_LEVEL; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rdClk);
    repeat (6) @(negedge wrClk);
  endtask

  task automatic wrWord(input logic [DATA_W-1:0] d);
    @(negedge wrClk); wrEn = 1; wrData = d;
    @(negedge wrClk); wrEn = 0;
  endtask

  task automatic rdWord(output logic [DATA_W-1:0] d);
    @(negedge rdClk); rdEn = 1;
    @(negedge rdClk); rdEn = 0; d = rdData;
  endtask

  task automatic globalReset();
    @(negedge wrClk); rst = 1;
    repeat (3) @(negedge rdClk);
    rst = 0;
    settle();
  endtask

  task automatic checkIdle(string req);
    chk({req, " empty"}, empty, 1);
    chk({req, " almostEmpty"}, almostEmpty, 1);
    chk({req, " full"}, full, 0);
    chk({req, " almostFull"}, almostFull, 0);
    chk({req, " rdData"}, rdData, 0);
  endtask

  task automatic writer(int n);
    for (int i = 0; i < n; i++) begin
      int pw;
      @(negedge wrClk);
      pw = ((i / 400) % 2) ? 85 : 35;
      wrEn = (($urandom % 100) < pw);
      wrData = DATA_W'($urandom);
      if (wrEn && !full) model.push_back(wrData);
    end
    @(negedge wrClk); wrEn = 0;
  endtask

  task automatic reader(int n);
    logic pend = 0;
    logic [DATA_W-1:0] expv = '0;
    for (int i = 0; i < n; i++) begin
      int pr;
      @(negedge rdClk);
      if (pend) chk("R2 random order", rdData, expv);
      pend = 0;
      pr = ((i / 300) % 2) ? 35 : 85;
      rdEn = (($urandom % 100) < pr);
      if (rdEn && !empty) begin
        if (model.size() == 0) chk("R4 read past model", 1, 0);
        else begin expv = model.pop_front(); pend = 1; end
      end
    end
    @(negedge rdClk); rdEn = 0;
    if (pend) chk("R2 random order", rdData, expv);
  endtask

  initial begin
    repeat (200000) @(posedge wrClk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge rdClk);
    checkIdle("R1 in reset");
    rst = 0;
    settle();
    checkIdle("R1 after reset");

    // R5/R7: single write, empty lags, then clears
    wrWord(8'hA0);
    chk("R5 empty still set after write", empty, 1);
    settle();
    chk("R5 empty cleared", empty, 0);
    chk("R7 almostEmpty fill 1", almostEmpty, expAe(1));
    for (int i = 1; i < 3; i++) wrWord(8'hA0 + DATA_W'(i));
    settle();
    chk("R7 almostEmpty fill 3", almostEmpty, expAe(3));
    wrWord(8'hA3);
    settle();
    chk("R7 almostEmpty fill 4", almostEmpty, expAe(4));
    for (int i = 4; i < AF_LEVEL - 1; i++) wrWord(8'hA0 + DATA_W'(i));
    settle();
    chk("R6 almostFull below level", almostFull, 0);
    wrWord(8'hA0 + DATA_W'(AF_LEVEL - 1));
    chk("R6 almostFull at level immediate", almostFull, 1);
    for (int i = AF_LEVEL; i < DEPTH - 1; i++) wrWord(8'hA0 + DATA_W'(i));
    chk("R3 not full at depth-1", full, 0);
    wrWord(8'hA0 + DATA_W'(DEPTH - 1));
    chk("R3 full immediate", full, 1);
    chk("R10 full implies almostFull", almostFull, 1);

    // R3: writes while full are dropped
    @(negedge wrClk); wrEn = 1; wrData = 8'hEE;
    repeat (3) @(negedge wrClk);
    wrEn = 0;
    chk("R3 full holds under write", full, 1);

    rdWord(got);
    chk("R2 first word", got, 8'hA0);
    chk("R5 full still set after read", full, 1);
    settle();
    chk("R5 full cleared", full, 0);
    chk("R6 almostFull fill 15", almostFull, expAf(15));
    for (int i = 1; i < DEPTH; i++) begin
      rdWord(got);
      chk("R2 order", got, 8'hA0 + DATA_W'(i));
    end
    chk("R4 empty immediate", empty, 1);
    chk("R10 empty implies almostEmpty", almostEmpty, 1);
    settle();
    chk("R3 dropped writes absent", empty, 1);

    // R4: read while empty
    @(negedge rdClk); rdEn = 1;
    repeat (3) @(negedge rdClk);
    rdEn = 0;
    chk("R4 rdData held", rdData, 8'hAF);
    chk("R4 empty held", empty, 1);

    // R9: reset in the middle of traffic
    wrWord(8'h11); wrWord(8'h22); wrWord(8'h33);
    settle();
    globalReset();
    checkIdle("R9 mid reset");

    // R8: rewind the read pointer
    for (int i = 0; i < 5; i++) wrWord(8'hB0 + DATA_W'(i));
    settle();
    for (int i = 0; i < 5; i++) begin
      rdWord(got);
      chk("R8 first pass", got, 8'hB0 + DATA_W'(i));
    end
    settle();
    chk("R8 empty before rewind", empty, 1);
    @(negedge rdClk); rdPtrRst = 1;
    @(negedge rdClk); rdPtrRst = 0;
    settle();
    chk("R8 empty after rewind", empty, 0);
    chk("R8 almostEmpty after rewind", almostEmpty, expAe(5));
    for (int i = 0; i < 5; i++) begin
      rdWord(got);
      chk("R8 second pass", got, 8'hB0 + DATA_W'(i));
    end
    chk("R8 empty after second pass", empty, 1);

    // random traffic
    globalReset();
    model.delete();
    fork
      writer(3000);
      reader(2400);
    join
    settle();
    for (int i = 0; i < 40 && !empty; i++) begin
      rdWord(got);
      if (model.size() == 0) chk("R4 extra word", 1, 0);
      else chk("R2 drain order", got, model.pop_front());
    end
    settle();
    chk("R2 model drained", model.size(), 0);
    chk("R4 empty at end", empty, 1);
    chk("R3 full at end", full, 0);
    chk("R6 almostFull at end", almostFull, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule